// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Systematic Encoder

This block is a bit-serial systematic encoder for a quasi-cyclic LDPC code. The parity part of the code's generator is built from square T×T circulants, arranged as `K_BLK` block-rows by `P_BLK` parity block-columns. Message bits arrive one per clock over a valid/ready handshake. Each one is forwarded in the same cycle to the serial codeword output. Every accepted bit is also folded into `P_BLK` rotating parity accumulators, each T bits wide. The pattern folded in comes from a combinational function of the current block-row, so no circulant row is ever held in a register.

After the `K_BLK*T` message bits of a frame, the block stops taking input and shifts the `P_BLK*T` parity bits out on the same serial port. It then waits for the next frame. Backpressure on the output stalls the flow in either phase. With the default parameters the block encodes frames of 1024 message bits into 2048-bit codewords.

Top module: `qc_ldpc_enc`

## Requirements
- R1: After reset the block is at the first message bit of a frame. `out_last` is low, `out_valid` is low while `in_valid` is low, and `in_ready` follows `out_ready`.
- R2: In the message phase `out_valid` equals `in_valid`, `out_data` equals `in_data` and `in_ready` equals `out_ready`, all in the same cycle. A bit is consumed on a cycle where `in_valid` and `out_ready` are both high.
- R3: Message bit s (0-based, in order of arrival) lies in block-row b = s / T at offset t = s mod T. Bit x^i of the circulant first row for block-row b and parity column j is `GEN_ROWS[(b*P_BLK + j)*T + i]`. When `HASH_FILL` is 0 the pattern is that table bit alone. Parity bit i of column j is the XOR, over all message bits equal to 1, of first-row bit (i − t) mod T. Each circulant row is thus the row above it shifted cyclically by one place toward higher powers.
- R4: Parity is sent starting on the cycle after the last message bit is consumed. Column 0 goes first and column `P_BLK-1` last, and within a column bit 0 goes first.
- R5: For the whole parity phase `in_ready` is low and `out_valid` is high.
- R6: `out_last` is high only with the final parity bit of a frame.
- R7: While `out_ready` is low, `in_ready` is low and no symbol is consumed. A parity symbol that is held keeps its value. No symbol is lost or repeated.
- R8: Consecutive frames are encoded independently. The parity of each frame depends only on that frame's message, including after a reset in the middle of a frame.
- R9: The pattern changes exactly at block-row boundaries. A single 1 at the first or last offset of any block-row gives the parity that R3 defines for that row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message bit is offered |
| in_ready | output | 1 | The message bit is taken this cycle when in_valid is high |
| in_data | input | 1 | Message bit |
| out_valid | output | 1 | A codeword symbol is offered |
| out_ready | input | 1 | The downstream side takes the symbol |
| out_data | output | 1 | Codeword symbol |
| out_last | output | 1 | Marks the final parity symbol of a frame |

## Verification
A wrong accumulator bit, such as a wrong rotation direction or a pattern applied at the wrong offset, stays hidden until the parity phase. It then shows as a wrong parity symbol at a position the bench can predict from the message. A wrong block-row or position counter makes the phase switch early or late. That moves `in_ready` low, or moves `out_last`, on the wrong beat within one frame. A fault in the readout chain fill leaks one frame's parity into the next. It is therefore exposed by the second of two frames sent back to back.

// File: rtl/qcenc_pkg.sv
package qcenc_pkg;

   typedef enum logic {
      PH_MSG = 1'b0,
      PH_PAR = 1'b1
   } qcenc_phase_e;

   // Cheap mixing function used to fill circulant first rows when no
   // explicit table is supplied; depends on block-row, column and bit.
   function automatic logic hash_bit(input int unsigned b,
                                     input int unsigned j,
                                     input int unsigned i);
      logic [31:0] h;
      h = 32'h6d2b_79f5 ^ (32'(b) << 20) ^ (32'(j) << 10) ^ 32'(i);
      h = h ^ (h << 13);
      h = h ^ (h >> 17);
      h = h ^ (h << 5);
      return h[0] ^ h[7] ^ h[19];
   endfunction

endpackage

// File: rtl/qcenc_seq.sv
module qcenc_seq #(
   parameter int T     = 128,
   parameter int K_BLK = 8,
   parameter int P_BLK = 8,
   localparam int PW   = $clog2(T),
   localparam int BW   = (K_BLK > 1) ? $clog2(K_BLK) : 1,
   localparam int RDL  = P_BLK * T,
   localparam int RW   = $clog2(RDL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          out_ready,
   output logic          msg_phase,
   output logic          msg_fire,
   output logic          rd_fire,
   output logic [BW-1:0] blk_idx,
   output logic          last_beat
);
   import qcenc_pkg::*;

   qcenc_phase_e  phase_q;
   logic [PW-1:0] pos_q;
   logic [BW-1:0] blk_q;
   logic [RW-1:0] rd_q;

   logic pos_end, blk_end, rd_end;

   assign pos_end   = (pos_q == PW'(T - 1));
   assign blk_end   = (blk_q == BW'(K_BLK - 1));
   assign rd_end    = (rd_q == RW'(RDL - 1));

   assign msg_phase = (phase_q == PH_MSG);
   assign msg_fire  = msg_phase && in_valid && out_ready;
   assign rd_fire   = !msg_phase && out_ready;
   assign blk_idx   = blk_q;
   assign last_beat = !msg_phase && rd_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_MSG;
         pos_q   <= '0;
         blk_q   <= '0;
         rd_q    <= '0;
      end else if (msg_fire) begin
         if (pos_end) begin
            pos_q <= '0;
            if (blk_end) begin
               blk_q   <= '0;
               phase_q <= PH_PAR;
            end else begin
               blk_q <= blk_q + 1'b1;
            end
         end else begin
            pos_q <= pos_q + 1'b1;
         end
      end else if (rd_fire) begin
         if (rd_end) begin
            rd_q    <= '0;
            phase_q <= PH_MSG;
         end else begin
            rd_q <= rd_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/qcenc_pattern.sv
module qcenc_pattern #(
   parameter int T        = 128,
   parameter int K_BLK    = 8,
   parameter int P_BLK    = 8,
   parameter bit HASH_FILL = 1'b1,
   parameter logic [K_BLK*P_BLK*T-1:0] GEN_ROWS = '0,
   localparam int BW      = (K_BLK > 1) ? $clog2(K_BLK) : 1
) (
   input  logic [BW-1:0]      blk_idx,
   output logic [P_BLK*T-1:0] pat
);

   for (genvar j = 0; j < P_BLK; j++) begin : g_col
      logic [T-1:0] tab_row;
      logic [T-1:0] mix_row;

      always_comb begin
         tab_row = GEN_ROWS[(int'(blk_idx) * P_BLK + j) * T +: T];
      end

      if (HASH_FILL) begin : g_hash
         always_comb begin
            for (int i = 0; i < T; i++) begin
               mix_row[i] = qcenc_pkg::hash_bit(int'(blk_idx), j, i);
            end
         end
      end else begin : g_plain
         assign mix_row = '0;
      end

      assign pat[j*T +: T] = tab_row ^ mix_row;
   end

endmodule

// File: rtl/qcenc_acc_lane.sv
module qcenc_acc_lane #(
   parameter int T = 128
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         msg_fire,
   input  logic         rd_fire,
   input  logic         msg_bit,
   input  logic [T-1:0] pattern,
   input  logic         chain_in,
   output logic         chain_out
);

   logic [T-1:0] acc_q;
   logic [T-1:0] folded;

   // add the pattern, then rotate one place toward bit 0
   assign folded    = acc_q ^ (msg_bit ? pattern : '0);
   assign chain_out = acc_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (msg_fire) begin
         acc_q <= {folded[0], folded[T-1:1]};
      end else if (rd_fire) begin
         acc_q <= {chain_in, acc_q[T-1:1]};
      end
   end

endmodule

// File: rtl/qc_ldpc_enc.sv
module qc_ldpc_enc #(
   parameter int T         = 128,
   parameter int K_BLK     = 8,
   parameter int P_BLK     = 8,
   parameter bit HASH_FILL = 1'b1,
   parameter logic [K_BLK*P_BLK*T-1:0] GEN_ROWS = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic in_ready,
   input  logic in_data,
   output logic out_valid,
   input  logic out_ready,
   output logic out_data,
   output logic out_last
);
   localparam int BW = (K_BLK > 1) ? $clog2(K_BLK) : 1;

   if (T < 2) begin : g_bad_t
      $error("qc_ldpc_enc: T must be at least 2");
   end
   if (K_BLK < 1 || P_BLK < 1) begin : g_bad_blk
      $error("qc_ldpc_enc: K_BLK and P_BLK must be positive");
   end

   logic               msg_phase, msg_fire, rd_fire, last_beat;
   logic [BW-1:0]      blk_idx;
   logic [P_BLK*T-1:0] pat;
   logic [P_BLK:0]     link;

   qcenc_seq #(.T(T), .K_BLK(K_BLK), .P_BLK(P_BLK)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .msg_phase (msg_phase),
      .msg_fire  (msg_fire),
      .rd_fire   (rd_fire),
      .blk_idx   (blk_idx),
      .last_beat (last_beat)
   );

   qcenc_pattern #(
      .T(T), .K_BLK(K_BLK), .P_BLK(P_BLK),
      .HASH_FILL(HASH_FILL), .GEN_ROWS(GEN_ROWS)
   ) i_pattern (
      .blk_idx (blk_idx),
      .pat     (pat)
   );

   // readout chain: column 0 drains first, zeros fill from the top
   assign link[P_BLK] = 1'b0;

   for (genvar j = 0; j < P_BLK; j++) begin : g_lane
      qcenc_acc_lane #(.T(T)) i_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .msg_fire  (msg_fire),
         .rd_fire   (rd_fire),
         .msg_bit   (in_data),
         .pattern   (pat[j*T +: T]),
         .chain_in  (link[j+1]),
         .chain_out (link[j])
      );
   end

   assign in_ready  = msg_phase && out_ready;
   assign out_valid = msg_phase ? in_valid : 1'b1;
   assign out_data  = msg_phase ? in_data  : link[0];
   assign out_last  = last_beat;

endmodule

// File: rtl/qc_ldpc_enc_chk.sv
module qc_ldpc_enc_chk #(
   parameter int T     = 128,
   parameter int K_BLK = 8,
   parameter int P_BLK = 8,
   localparam int MSGL = K_BLK * T,
   localparam int FRL  = (K_BLK + P_BLK) * T,
   localparam int CW   = $clog2(FRL + 1)
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_ready,
   input logic in_data,
   input logic out_valid,
   input logic out_ready,
   input logic out_data,
   input logic out_last
);
   logic [CW-1:0] beat_q;
   logic          beat, in_par;

   assign beat   = out_valid && out_ready;
   assign in_par = (beat_q >= CW'(MSGL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      beat_q <= '0;
      else if (beat)   beat_q <= (beat_q == CW'(FRL - 1)) ? '0 : beat_q + 1'b1;
   end

   a_r2_copy_through: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_par && in_valid && out_ready) |-> (out_valid && in_ready && out_data == in_data));

   a_r5_readout_no_input: assert property (@(posedge clk) disable iff (!rst_n)
      in_par |-> (!in_ready && out_valid));

   a_r6_last_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> (out_valid && beat_q == CW'(FRL - 1)));

   a_r6_end_has_last: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_q == CW'(FRL - 1)) |-> out_last);

   a_r7_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready |-> !in_ready);

   a_r7_held_symbol_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (in_par && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind qc_ldpc_enc qc_ldpc_enc_chk #(.T(T), .K_BLK(K_BLK), .P_BLK(P_BLK)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_last  (out_last)
);

// File: tb/test_qc_ldpc_enc.sv
module test_qc_ldpc_enc;
   localparam int TT  = 5;
   localparam int KB  = 3;
   localparam int PB  = 2;
   localparam int ML  = KB * TT;
   localparam int PL  = PB * TT;
   localparam int FL  = ML + PL;
   localparam logic [KB*PB*TT-1:0] GEN = 30'h1A5C3E97;

   localparam int NV = 9;
   localparam logic [ML-1:0] MSG_TAB [NV] = '{
      15'h0000, 15'h0001, 15'h0010, 15'h0020, 15'h0200,
      15'h4000, 15'h7FFF, 15'h5A3C, 15'h2B71};
   localparam logic [31:0] GAP_TAB [NV] = '{
      32'h0000_0000, 32'h0000_0000, 32'h8421_0842, 32'h0000_0000, 32'h0F00_00F0,
      32'h0000_0000, 32'h1248_8124, 32'hF000_000F, 32'h0000_0000};
   localparam int HOLD_TAB [NV] = '{-1, -1, -1, 17, -1, 24, -1, -1, 15};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_data = 1'b0, out_ready = 1'b1;
   logic in_ready, out_valid, out_data, out_last;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   qc_ldpc_enc #(.T(TT), .K_BLK(KB), .P_BLK(PB), .HASH_FILL(1'b0), .GEN_ROWS(GEN))
   i_qc_ldpc_enc (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_last(out_last));

   function automatic logic [PL-1:0] model_parity(input logic [ML-1:0] m);
      logic [PL-1:0] p = '0;
      for (int s = 0; s < ML; s++) begin
         if (m[s]) begin
            for (int j = 0; j < PB; j++) begin
               for (int i = 0; i < TT; i++) begin
                  p[j*TT+i] ^= GEN[((s/TT)*PB + j)*TT + ((i - (s%TT) + TT) % TT)];
               end
            end
         end
      end
      return p;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_frame(input logic [ML-1:0] msg, input logic [31:0] gap, input int hold_at);
      int sent = 0, got = 0, c = 0;
      logic [FL-1:0] seen = '0;
      bit last_ok = 1'b1, rdy_ok = 1'b1, held = 1'b0;
      logic hv;
      while (got < FL && c < 400) begin
         if (got == hold_at && !held) begin
            held = 1'b1;
            for (int h = 0; h < 5; h++) begin
               @(negedge clk);
               out_ready = 1'b0; in_valid = 1'b0; in_data = 1'b0;
               #1;
               if (h == 0) hv = out_data;
               check(out_valid && out_data == hv && !in_ready, "R7", "held parity symbol",
                     {out_valid, out_data}, {1'b1, hv});
            end
         end
         @(negedge clk);
         out_ready = !gap[c%32];
         in_valid  = (sent < ML) && !gap[(c+7)%32];
         in_data   = in_valid ? msg[sent] : 1'b0;
         #1;
         if (got >= ML && (in_ready || !out_valid)) rdy_ok = 1'b0;
         if (out_valid && out_ready) begin
            seen[got] = out_data;
            if (out_last != (got == FL-1)) last_ok = 1'b0;
            if (in_valid && in_ready) sent++;
            got++;
         end
         c++;
      end
      @(negedge clk);
      in_valid = 1'b0; in_data = 1'b0; out_ready = 1'b1;
      check(seen[ML-1:0] == msg, "R2", "systematic part", 32'(seen[ML-1:0]), 32'(msg));
      check(seen[FL-1:ML] == model_parity(msg), "R3 R4 R9", "parity part",
            32'(seen[FL-1:ML]), 32'(model_parity(msg)));
      check(last_ok, "R6", "out_last placement", 32'(last_ok), 32'd1);
      check(rdy_ok, "R5", "readout handshake", 32'(rdy_ok), 32'd1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R1: reset state
      check(!out_valid, "R1", "out_valid idle", 32'(out_valid), 32'd0);
      check(in_ready, "R1", "in_ready follows out_ready", 32'(in_ready), 32'd1);
      check(!out_last, "R1", "out_last idle", 32'(out_last), 32'd0);
      @(negedge clk);
      out_ready = 1'b0; #1;
      check(!in_ready, "R7", "in_ready with out_ready low", 32'(in_ready), 32'd0);
      @(negedge clk);
      out_ready = 1'b1;

      // table of frames, back to back (R8 independence)
      for (int v = 0; v < NV; v++) begin
         run_frame(MSG_TAB[v], GAP_TAB[v], HOLD_TAB[v]);
      end

      // R8: reset in the middle of a frame, then a clean frame
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = c[0] ^ c[2];
      end
      @(negedge clk);
      in_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      run_frame(15'h0421, 32'h0, -1);
      run_frame(15'h7FFF, 32'h0, 20);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule